// File: doc/BRIEF.md
# Indexed Bottom-Element Vector Operand Selector

This block sits in front of a row of per-lane widening multiply-accumulate units in a vector datapath whose width VL is a multiple of 128 bits. Each 16-bit result lane needs three operands: a byte from the first source vector, a byte from the second source vector and a 16-bit accumulator element. The selector steers all three out of the full-width inputs at once. Lane e takes the bottom (even-numbered) byte 2*e of the first source. It takes one byte of the second source that is broadcast across its whole 128-bit segment and chosen there by a 4-bit index. It takes halfword e of the accumulator vector.

The index reaches the block as two fields, a 1-bit upper part and a 3-bit lower part. They are joined upper-then-lower, so the upper bit picks the high or low half of the segment. The per-lane arithmetic is outside the block. Its lane results come back on a VL-bit input and are packed into the output vector. With the default register stage this takes one cycle, marked by an output valid strobe. There is no back-pressure.

Top module: `bottom_idx_lane_router`

## Requirements
- R1: There are VL/16 result lanes. The first-operand byte presented to lane e is byte 2*e of the first source, at bits [16e+7:16e].
- R2: The second-operand byte presented to lane e is byte 16*(e/8) + idx of the second source, where idx = {idx_hi, idx_lo} (idx_hi is bit 3).
- R3: All eight lanes of one 128-bit segment present the same second-operand byte.
- R4: The accumulator element presented to lane e is bits [16e+15:16e] of the accumulator source.
- R5: The odd-numbered bytes of the first source have no effect on any lane output.
- R6: With the register stage enabled, out_valid is high exactly in the cycle after a cycle with in_valid high. In that cycle out_vec equals the lane_res value that was present when in_valid was high, and lane e's result sits at bits [16e+15:16e].
- R7: While rst is high at a clock edge, out_valid and out_vec clear to zero on that edge.
- R8: A cycle with in_valid low leaves out_vec unchanged and drives out_valid low one cycle later.
- R9: Index values 8 to 15 select bytes from the upper half of each segment (byte offsets 8 to 15), so every byte of a segment can be reached.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and lane results are valid this cycle |
| src_a | input | VL | First source vector of bytes; only even bytes are used |
| src_b | input | VL | Second source vector of bytes; one byte per segment is broadcast |
| src_acc | input | VL | Accumulator vector of 16-bit elements |
| idx_hi | input | 1 | Upper bit of the 4-bit segment-relative index |
| idx_lo | input | 3 | Lower three bits of the segment-relative index |
| lane_a | output | VL/2 | First-operand byte per lane, lane e at bits [8e+7:8e] |
| lane_b | output | VL/2 | Second-operand byte per lane, lane e at bits [8e+7:8e] |
| lane_acc | output | VL | Accumulator element per lane, lane e at bits [16e+15:16e] |
| lane_res | input | VL | Per-lane results from the arithmetic units, lane e at bits [16e+15:16e] |
| out_valid | output | 1 | Packed output is valid |
| out_vec | output | VL | Packed result vector |

## Verification
The assertions assume three things about the inputs. Reset is held high from the first edge. The sources, index and lane results stay stable between clock edges. lane_res is a same-cycle function of the lane outputs, so the value captured in the valid cycle is the one the checker sees through $past. The bench keeps to this. It holds reset from time zero and changes every input a short time after the rising edge. It computes lane_res with a combinational stub on the lane outputs of each instance, so the captured result always matches the operands that were presented.

// File: rtl/bidx_pkg.sv
package bidx_pkg;

    localparam int BYTE_W        = 8;
    localparam int HALF_W        = 16;
    localparam int SEG_W         = 128;
    localparam int IDX_W         = 4;
    localparam int LANES_PER_SEG = SEG_W / HALF_W;
    localparam int BYTES_PER_SEG = SEG_W / BYTE_W;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [HALF_W-1:0] half_t;
    typedef logic [IDX_W-1:0]  seg_idx_t;

    // Split index as it arrives at the pins: upper bit, then three lower bits.
    typedef struct packed {
        logic       hi;
        logic [2:0] lo;
    } idx_split_t;

    // Operands handed to one result lane.
    typedef struct packed {
        byte_t a;
        byte_t b;
        half_t acc;
    } lane_ops_t;

    function automatic seg_idx_t idx_join(idx_split_t s);
        return {s.hi, s.lo};
    endfunction

    function automatic int unsigned lane_count(int unsigned vl);
        return vl / HALF_W;
    endfunction

    function automatic int unsigned seg_count(int unsigned vl);
        return vl / SEG_W;
    endfunction

endpackage

// File: rtl/bidx_even_pick.sv
module bidx_even_pick
    import bidx_pkg::*;
#(
    parameter int VL = 256
) (
    input  logic [VL-1:0]   src,
    output logic [VL/2-1:0] picked
);
    localparam int LANES = VL / HALF_W;

    // Lane e takes byte 2e, which is the low byte of halfword e.
    for (genvar e = 0; e < LANES; e++) begin : g_lane
        assign picked[e*BYTE_W +: BYTE_W] = src[e*HALF_W +: BYTE_W];
    end

endmodule

// File: rtl/bidx_seg_bcast.sv
module bidx_seg_bcast
    import bidx_pkg::*;
#(
    parameter int VL = 256
) (
    input  logic [VL-1:0]    src,
    input  seg_idx_t         idx,
    output logic [VL/2-1:0]  bcast
);
    localparam int SEGS = VL / SEG_W;

    for (genvar s = 0; s < SEGS; s++) begin : g_seg
        logic [SEG_W-1:0] seg_bits;
        byte_t            pick;

        assign seg_bits = src[s*SEG_W +: SEG_W];

        // One 16:1 byte mux per segment, shared by its eight lanes.
        always_comb begin
            pick = '0;
            for (int k = 0; k < BYTES_PER_SEG; k++) begin
                if (idx == IDX_W'(k)) begin
                    pick = seg_bits[k*BYTE_W +: BYTE_W];
                end
            end
        end

        for (genvar l = 0; l < LANES_PER_SEG; l++) begin : g_fan
            assign bcast[(s*LANES_PER_SEG + l)*BYTE_W +: BYTE_W] = pick;
        end
    end

endmodule

// File: rtl/bidx_pack_stage.sv
module bidx_pack_stage
    import bidx_pkg::*;
#(
    parameter int VL      = 256,
    parameter bit REG_OUT = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [VL-1:0] lane_res,
    output logic          out_valid,
    output logic [VL-1:0] out_vec
);
    localparam int LANES = VL / HALF_W;

    // Gather lane results in lane order.
    half_t       res_lane [LANES];
    logic [VL-1:0] packed_res;

    for (genvar e = 0; e < LANES; e++) begin : g_gather
        assign res_lane[e] = lane_res[e*HALF_W +: HALF_W];
        assign packed_res[e*HALF_W +: HALF_W] = res_lane[e];
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                out_valid <= 1'b0;
                out_vec   <= '0;
            end else begin
                out_valid <= in_valid;
                if (in_valid) begin
                    out_vec <= packed_res;
                end
            end
        end
    end else begin : g_comb
        assign out_valid = in_valid;
        assign out_vec   = packed_res;
    end

endmodule

// File: rtl/bottom_idx_lane_router.sv
module bottom_idx_lane_router
    import bidx_pkg::*;
#(
    parameter int VL      = 256,
    parameter bit REG_OUT = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [VL-1:0]   src_a,
    input  logic [VL-1:0]   src_b,
    input  logic [VL-1:0]   src_acc,
    input  logic            idx_hi,
    input  logic [2:0]      idx_lo,
    output logic [VL/2-1:0] lane_a,
    output logic [VL/2-1:0] lane_b,
    output logic [VL-1:0]   lane_acc,
    input  logic [VL-1:0]   lane_res,
    output logic            out_valid,
    output logic [VL-1:0]   out_vec
);
    localparam int LANES = VL / HALF_W;

    idx_split_t       idx_in;
    seg_idx_t         idx;
    logic [VL/2-1:0]  even_bytes;
    logic [VL/2-1:0]  seg_bytes;
    lane_ops_t        ops [LANES];

    assign idx_in = '{hi: idx_hi, lo: idx_lo};
    assign idx    = idx_join(idx_in);

    bidx_even_pick #(.VL(VL)) u_even (
        .src    (src_a),
        .picked (even_bytes)
    );

    bidx_seg_bcast #(.VL(VL)) u_bcast (
        .src   (src_b),
        .idx   (idx),
        .bcast (seg_bytes)
    );

    for (genvar e = 0; e < LANES; e++) begin : g_lane
        assign ops[e].a   = even_bytes[e*BYTE_W +: BYTE_W];
        assign ops[e].b   = seg_bytes[e*BYTE_W +: BYTE_W];
        assign ops[e].acc = src_acc[e*HALF_W +: HALF_W];

        assign lane_a[e*BYTE_W +: BYTE_W]   = ops[e].a;
        assign lane_b[e*BYTE_W +: BYTE_W]   = ops[e].b;
        assign lane_acc[e*HALF_W +: HALF_W] = ops[e].acc;
    end

    bidx_pack_stage #(.VL(VL), .REG_OUT(REG_OUT)) u_pack (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .lane_res  (lane_res),
        .out_valid (out_valid),
        .out_vec   (out_vec)
    );

endmodule

// File: rtl/bidx_checker.sv
module bidx_checker
    import bidx_pkg::*;
#(
    parameter int VL      = 256,
    parameter bit REG_OUT = 1'b1
) (
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic [VL-1:0]   src_b,
    input logic            idx_hi,
    input logic [2:0]      idx_lo,
    input logic [VL/2-1:0] lane_b,
    input logic [VL-1:0]   lane_res,
    input logic            out_valid,
    input logic [VL-1:0]   out_vec
);
    localparam int LANES = VL / HALF_W;

    for (genvar e = 0; e < LANES; e++) begin : g_lane
        localparam int SEG_FIRST = (e / LANES_PER_SEG) * LANES_PER_SEG;
        logic [3:0] sel;
        byte_t      want_b;
        assign sel    = {idx_hi, idx_lo};
        assign want_b = src_b[(e / LANES_PER_SEG)*SEG_W + int'(sel)*BYTE_W +: BYTE_W];

        assert_lane_b_R2: assert property (@(posedge clk) disable iff (rst)
            lane_b[e*BYTE_W +: BYTE_W] == want_b);

        if (e != SEG_FIRST) begin : g_share
            assert_seg_share_R3: assert property (@(posedge clk) disable iff (rst)
                lane_b[e*BYTE_W +: BYTE_W] == lane_b[SEG_FIRST*BYTE_W +: BYTE_W]);
        end
    end

    if (REG_OUT) begin : g_reg_chk
        assert_valid_follows_R6: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> out_valid);
        assert_capture_R6: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> (out_vec == $past(lane_res)));
        assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> (!out_valid && $stable(out_vec)));
        assert_reset_clear_R7: assert property (@(posedge clk)
            rst |=> (!out_valid && out_vec == '0));
    end

endmodule

bind bottom_idx_lane_router bidx_checker #(.VL(VL), .REG_OUT(REG_OUT)) u_bidx_checker (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .src_b     (src_b),
    .idx_hi    (idx_hi),
    .idx_lo    (idx_lo),
    .lane_b    (lane_b),
    .lane_res  (lane_res),
    .out_valid (out_valid),
    .out_vec   (out_vec)
);

// File: tb/bottom_idx_lane_router_bench.sv
`timescale 1ns/1ps
module bottom_idx_lane_router_bench;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic         rst;
    logic         in_valid;
    logic [511:0] a_v, b_v, c_v;
    logic [3:0]   idx_v;

    logic [255:0] la0, lb0, la1, lb1;
    logic [511:0] lacc0, lacc1, res0, res1, ov0, ov1;
    logic         vld0, vld1;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    bottom_idx_lane_router #(.VL(256), .REG_OUT(1'b1)) u_bottom_idx_lane_router (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .src_a(a_v[255:0]), .src_b(b_v[255:0]), .src_acc(c_v[255:0]),
        .idx_hi(idx_v[3]), .idx_lo(idx_v[2:0]),
        .lane_a(la0[127:0]), .lane_b(lb0[127:0]), .lane_acc(lacc0[255:0]),
        .lane_res(res0[255:0]), .out_valid(vld0), .out_vec(ov0[255:0])
    );

    bottom_idx_lane_router #(.VL(512), .REG_OUT(1'b1)) u_bottom_idx_lane_router_w512 (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .src_a(a_v), .src_b(b_v), .src_acc(c_v),
        .idx_hi(idx_v[3]), .idx_lo(idx_v[2:0]),
        .lane_a(la1), .lane_b(lb1), .lane_acc(lacc1),
        .lane_res(res1), .out_valid(vld1), .out_vec(ov1)
    );

    assign la0[255:128]   = '0;
    assign lb0[255:128]   = '0;
    assign lacc0[511:256] = '0;
    assign ov0[511:256]   = '0;

    // Arithmetic stub: accumulator plus the two operand bytes as a halfword.
    always_comb begin
        res0 = '0;
        res1 = '0;
        for (int e = 0; e < 16; e++)
            res0[e*16 +: 16] = lacc0[e*16 +: 16] + {la0[e*8 +: 8], lb0[e*8 +: 8]};
        for (int e = 0; e < 32; e++)
            res1[e*16 +: 16] = lacc1[e*16 +: 16] + {la1[e*8 +: 8], lb1[e*8 +: 8]};
    end

    function automatic logic [7:0] exp_a(int e);
        return a_v[16*e +: 8];
    endfunction

    function automatic logic [7:0] exp_b(int e);
        return b_v[128*(e/8) + 8*int'(idx_v) +: 8];
    endfunction

    function automatic logic [511:0] exp_out(int nl);
        logic [511:0] r = '0;
        for (int e = 0; e < nl; e++)
            r[16*e +: 16] = c_v[16*e +: 16] + {exp_a(e), exp_b(e)};
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [511:0] act, input logic [511:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_lanes(input int nl, input logic [255:0] la, input logic [255:0] lb,
                               input logic [511:0] lacc, input string tag);
        for (int e = 0; e < nl; e++) begin
            chk(la[e*8 +: 8] == exp_a(e), $sformatf("R1 %s lane %0d a", tag, e),
                512'(la[e*8 +: 8]), 512'(exp_a(e)));
            chk(lb[e*8 +: 8] == exp_b(e), $sformatf("R2/R3/R9 %s lane %0d b idx %0d", tag, e, idx_v),
                512'(lb[e*8 +: 8]), 512'(exp_b(e)));
            chk(lacc[e*16 +: 16] == c_v[e*16 +: 16], $sformatf("R4 %s lane %0d acc", tag, e),
                512'(lacc[e*16 +: 16]), 512'(c_v[e*16 +: 16]));
        end
    endtask

    task automatic rand_vecs();
        for (int w = 0; w < 16; w++) begin
            a_v[w*32 +: 32] = $urandom;
            b_v[w*32 +: 32] = $urandom;
            c_v[w*32 +: 32] = $urandom;
        end
    endtask

    // Called just after a rising edge; returns just after the next one.
    task automatic run_txn(input logic [3:0] idx, input string tag);
        logic [511:0] e0, e1;
        idx_v    = idx;
        in_valid = 1'b1;
        #1;
        check_lanes(16, la0, lb0, lacc0, {tag, " w256"});
        check_lanes(32, la1, lb1, lacc1, {tag, " w512"});
        e0 = exp_out(16);
        e1 = exp_out(32);
        @(posedge clk); #1;
        chk(vld0 && vld1, {"R6 valid ", tag}, 512'({vld0, vld1}), 512'(2'b11));
        chk(ov0 == e0, {"R6 out w256 ", tag}, ov0, e0);
        chk(ov1 == e1, {"R6 out w512 ", tag}, ov1, e1);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        logic [511:0] hold0, hold1;
        logic [255:0] snap_a0, snap_a1;
        void'($urandom(32'd20240611));
        rst = 1'b1; in_valid = 1'b0; a_v = '0; b_v = '0; c_v = '0; idx_v = '0;
        repeat (3) @(posedge clk);
        #1;
        in_valid = 1'b1;          // must be ignored while reset is high
        rand_vecs();
        @(posedge clk); #1;
        chk(!vld0 && !vld1, "R7 reset valid", 512'({vld0, vld1}), '0);
        chk(ov0 == '0 && ov1 == '0, "R7 reset out", ov1, '0);
        rst = 1'b0; in_valid = 1'b0;
        @(posedge clk); #1;

        // Every index value, including the upper half of each segment (R9).
        for (int i = 0; i < 16; i++) begin
            rand_vecs();
            run_txn(4'(i), $sformatf("R9 dir idx %0d", i));
        end

        // Odd bytes of the first source are ignored (R5).
        rand_vecs();
        idx_v = 4'd5;
        #1;
        snap_a0 = la0; snap_a1 = la1;
        for (int e = 0; e < 32; e++) a_v[16*e + 8 +: 8] = ~a_v[16*e + 8 +: 8];
        #1;
        chk(la0 == snap_a0, "R5 odd bytes w256", 512'(la0), 512'(snap_a0));
        chk(la1 == snap_a1, "R5 odd bytes w512", 512'(la1), 512'(snap_a1));
        run_txn(4'd5, "R5 odd flip");

        // Idle cycles hold the output and drop valid (R8).
        hold0 = ov0; hold1 = ov1;
        in_valid = 1'b0;
        rand_vecs();
        @(posedge clk); #1;
        chk(!vld0 && !vld1, "R8 idle valid", 512'({vld0, vld1}), '0);
        chk(ov0 == hold0, "R8 hold w256", ov0, hold0);
        chk(ov1 == hold1, "R8 hold w512", ov1, hold1);
        rand_vecs();
        @(posedge clk); #1;
        chk(ov1 == hold1, "R8 hold second idle", ov1, hold1);

        // Directed corner patterns: all-ones / all-zeros sources.
        a_v = '1; b_v = '0; c_v = '1;
        run_txn(4'd15, "R2 corner ones");
        a_v = '0; b_v = '1; c_v = '0;
        run_txn(4'd0, "R2 corner zeros");

        // Random mix with occasional idle cycles.
        for (int t = 0; t < 60; t++) begin
            rand_vecs();
            if (($urandom % 5) == 0) begin
                hold1 = ov1;
                in_valid = 1'b0;
                @(posedge clk); #1;
                chk(!vld1 && ov1 == hold1, "R8 random idle", ov1, hold1);
            end else begin
                run_txn(4'($urandom), "R6 random");
            end
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule